// File: doc/BRIEF.md
# Sequential Sign-Magnitude Multiplier

This unit multiplies two signed words over many clock cycles and places the double-length product in a pair of result registers. The accumulator (AC) holds the high half and the multiplier-quotient register (MQ) holds the low half. Both operands are in sign-magnitude form, with the sign in the top bit. The multiplicand arrives on one input. The multiplier arrives on the other input and is loaded into MQ when the operation is accepted.

The magnitudes are multiplied with one shift-and-add step for each non-sign bit. A word of `WORD_W` bits therefore takes `WORD_W-1` steps. In each step the multiplicand magnitude is added to AC when the low bit of MQ is 1. The AC:MQ pair, together with the carry out of that add, then shifts right by one place, so the low bit of AC moves into the top of MQ's magnitude.

A final cycle writes the product sign into the top bit of both registers. The product sign is the XOR of the operand signs, except that a zero product is always given a positive sign. The controller is a four-state machine:

- `ST_IDLE` waits for a start pulse.
- `ST_STEP` runs the magnitude steps.
- `ST_SIGN` writes the sign.
- `ST_DONE` raises `done` for one cycle.

The transitions are:

- `ST_IDLE` goes to `ST_STEP` on a start pulse.
- `ST_STEP` stays in `ST_STEP` until the step counter reaches `WORD_W-2`, then goes to `ST_SIGN`.
- `ST_SIGN` always goes to `ST_DONE`.
- `ST_DONE` goes to `ST_STEP` when a start pulse is present, and to `ST_IDLE` otherwise.

Top module: `sm_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `ac_o` and `mq_o` are all zeros.
- R2: A `start` seen in `ST_IDLE` or `ST_DONE` captures `mcand_i` and `mplier_i`, and `busy` is 1 in the next cycle. Each operand is sign-magnitude: bit `WORD_W-1` is the sign (1 means negative) and the bits below it are the magnitude.
- R3: When `done` is 1, the concatenation {`ac_o[WORD_W-2:0]`, `mq_o[WORD_W-2:0]`} equals the product of the two operand magnitudes. The upper half of that product is in `ac_o`.
- R4: When `done` is 1 and the product magnitude is nonzero, `ac_o[WORD_W-1]` and `mq_o[WORD_W-1]` both equal the XOR of the two operand sign bits.
- R5: When the product magnitude is zero, both result sign bits are 0. This holds even when exactly one operand is negative, including an operand that is a negative zero.
- R6: `busy` stays 1 for exactly `WORD_W` cycles: `WORD_W-1` magnitude steps and one sign cycle. `done` rises on the `WORD_W`-th clock edge after the edge that accepted `start`.
- R7: `done` is a single-cycle pulse, and it appears exactly when `busy` falls.
- R8: A `start` pulse while `busy` is 1 is ignored. The running operation keeps its original operands and its timing.
- R9: While the unit is idle and `start` is 0, `ac_o` and `mq_o` keep their values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request; has an effect only when not busy |
| mcand_i | input | WORD_W | Multiplicand, sign-magnitude |
| mplier_i | input | WORD_W | Multiplier, sign-magnitude, loaded into MQ on start |
| busy | output | 1 | High during the step and sign cycles |
| done | output | 1 | One-cycle pulse when the result is final |
| ac_o | output | WORD_W | Accumulator: product sign and high magnitude half |
| mq_o | output | WORD_W | Multiplier-quotient: product sign and low magnitude half |

## Verification
The bench builds two copies of the unit. The first uses `WORD_W = 6`, which gives 5-bit magnitudes and 5 steps. At that size every pair of operand words, all 4096 of them, can be multiplied, and each result is compared with arithmetic done in the bench. That sweep reaches every carry pattern in the step adder, every sign combination, and every form of zero, including negative zero. The second copy keeps the default `WORD_W = 40` and runs directed cases with full magnitudes, a single magnitude bit, and mixed signs. Those cases check the 39-step timing and the split between the high and low halves at full width.

// File: rtl/sm_mult_pkg.sv
package sm_mult_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_SIGN = 2'd2,
        ST_DONE = 2'd3
    } sm_state_e;

endpackage

// File: rtl/sm_mult_ctrl.sv
module sm_mult_ctrl
    import sm_mult_pkg::*;
#(
    parameter int STEPS = 39
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fin,
    output logic busy,
    output logic done
);

    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    sm_state_e        state_q;
    sm_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    assign accept = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    // State register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= '0;
            end else if (state_q == ST_STEP) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_STEP;
            ST_STEP: if (cnt_q == LAST) state_d = ST_SIGN;
            ST_SIGN: state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_STEP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        load = accept;
        step = 1'b0;
        fin  = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_STEP: begin step = 1'b1; busy = 1'b1; end
            ST_SIGN: begin fin  = 1'b1; busy = 1'b1; end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sm_mult_sign.sv
module sm_mult_sign #(
    parameter int MAG_W = 39
) (
    input  logic             raw_sign,
    input  logic [MAG_W-1:0] hi_mag,
    input  logic [MAG_W-1:0] lo_mag,
    output logic             res_sign
);

    logic nonzero;

    // A zero product is always positive.
    assign nonzero  = (|hi_mag) || (|lo_mag);
    assign res_sign = raw_sign && nonzero;

endmodule

// File: rtl/sm_mult_dp.sv
module sm_mult_dp #(
    parameter int WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              fin,
    input  logic [WORD_W-1:0] mcand_i,
    input  logic [WORD_W-1:0] mplier_i,
    input  logic              res_sign,
    output logic [WORD_W-2:0] hi_mag,
    output logic [WORD_W-2:0] lo_mag,
    output logic              raw_sign,
    output logic [WORD_W-1:0] ac_o,
    output logic [WORD_W-1:0] mq_o
);

    localparam int MAG_W = WORD_W - 1;

    logic [MAG_W-1:0] acc_q;
    logic [MAG_W-1:0] mq_q;
    logic [MAG_W-1:0] mcand_q;
    logic             psign_q;
    logic             osign_q;
    logic [MAG_W:0]   addend;
    logic [MAG_W:0]   sum;

    // Add the multiplicand only when the current multiplier bit is 1.
    assign addend = mq_q[0] ? {1'b0, mcand_q} : '0;
    assign sum    = {1'b0, acc_q} + addend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mq_q    <= '0;
            mcand_q <= '0;
            psign_q <= 1'b0;
            osign_q <= 1'b0;
        end else if (load) begin
            acc_q   <= '0;
            mq_q    <= mplier_i[MAG_W-1:0];
            mcand_q <= mcand_i[MAG_W-1:0];
            psign_q <= mcand_i[WORD_W-1] ^ mplier_i[WORD_W-1];
            osign_q <= 1'b0;
        end else if (step) begin
            // Shift {carry, AC, MQ} right by one place.
            acc_q <= sum[MAG_W:1];
            mq_q  <= {sum[0], mq_q[MAG_W-1:1]};
        end else if (fin) begin
            osign_q <= res_sign;
        end
    end

    assign hi_mag   = acc_q;
    assign lo_mag   = mq_q;
    assign raw_sign = psign_q;
    assign ac_o     = {osign_q, acc_q};
    assign mq_o     = {osign_q, mq_q};

endmodule

// File: rtl/sm_mult.sv
module sm_mult #(
    parameter int WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] mcand_i,
    input  logic [WORD_W-1:0] mplier_i,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] ac_o,
    output logic [WORD_W-1:0] mq_o
);

    localparam int MAG_W = WORD_W - 1;
    localparam int STEPS = MAG_W;

    logic             load;
    logic             step;
    logic             fin;
    logic             raw_sign;
    logic             res_sign;
    logic [MAG_W-1:0] hi_mag;
    logic [MAG_W-1:0] lo_mag;

    sm_mult_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .fin   (fin),
        .busy  (busy),
        .done  (done)
    );

    sm_mult_dp #(.WORD_W(WORD_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .fin      (fin),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .res_sign (res_sign),
        .hi_mag   (hi_mag),
        .lo_mag   (lo_mag),
        .raw_sign (raw_sign),
        .ac_o     (ac_o),
        .mq_o     (mq_o)
    );

    sm_mult_sign #(.MAG_W(MAG_W)) u_sign (
        .raw_sign (raw_sign),
        .hi_mag   (hi_mag),
        .lo_mag   (lo_mag),
        .res_sign (res_sign)
    );

endmodule

// File: rtl/sm_mult_chk.sv
module sm_mult_chk #(
    parameter int WORD_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] ac_o,
    input logic [WORD_W-1:0] mq_o
);

    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LASTC = CW'(WORD_W - 1);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (!busy) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_zero_positive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (ac_o[WORD_W-2:0] == '0) && (mq_o[WORD_W-2:0] == '0))
            |-> (!ac_o[WORD_W-1] && !mq_o[WORD_W-1]));

    assert_sign_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ac_o[WORD_W-1] == mq_o[WORD_W-1]));

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (busy_cnt == LASTC)) |=> !busy);

    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (busy_cnt != LASTC)) |=> busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && (busy_cnt != LASTC)) |=> (busy && !done));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(ac_o) && $stable(mq_o)));

endmodule

bind sm_mult sm_mult_chk #(.WORD_W(WORD_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ac_o  (ac_o),
    .mq_o  (mq_o)
);

// File: tb/sm_mult_test.sv
module sm_mult_test;

    localparam int SW = 6;
    localparam int SM = SW - 1;
    localparam int LW = 40;
    localparam int LM = LW - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    // Small instance
    logic          s_start = 1'b0;
    logic [SW-1:0] s_a = '0;
    logic [SW-1:0] s_b = '0;
    logic          s_busy;
    logic          s_done;
    logic [SW-1:0] s_ac;
    logic [SW-1:0] s_mq;

    // Full-width instance
    logic          w_start = 1'b0;
    logic [LW-1:0] w_a = '0;
    logic [LW-1:0] w_b = '0;
    logic          w_busy;
    logic          w_done;
    logic [LW-1:0] w_ac;
    logic [LW-1:0] w_mq;

    int checks = 0;
    int fails  = 0;

    sm_mult #(.WORD_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .start(s_start), .mcand_i(s_a), .mplier_i(s_b),
        .busy(s_busy), .done(s_done), .ac_o(s_ac), .mq_o(s_mq)
    );

    sm_mult #(.WORD_W(LW)) uut_w (
        .clk(clk), .rst_n(rst_n), .start(w_start), .mcand_i(w_a), .mplier_i(w_b),
        .busy(w_busy), .done(w_done), .ac_o(w_ac), .mq_o(w_mq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // One operation on the small instance; optional start pulse while busy.
    task automatic run_s(input logic [SW-1:0] a, input logic [SW-1:0] b, input bit inject);
        logic [2*SM-1:0] p;
        logic            sg;
        int              lat;
        p  = (2*SM)'(a[SM-1:0]) * (2*SM)'(b[SM-1:0]);
        sg = (a[SW-1] ^ b[SW-1]) && (p != 0);
        @(negedge clk);
        s_a = a; s_b = b; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        check(s_busy == 1'b1, "R2", "busy after start", 80'(s_busy), 80'(1));
        lat = 0;
        while (!s_done && lat < 50) begin
            if (inject && lat == 2) begin
                s_a = ~a; s_b = ~b; s_start = 1'b1;
            end else begin
                s_start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        s_start = 1'b0;
        check(lat == SW, inject ? "R8" : "R6", "latency", 80'(lat), 80'(SW));
        check(s_busy == 1'b0, "R7", "busy low with done", 80'(s_busy), 80'(0));
        check({s_ac[SM-1:0], s_mq[SM-1:0]} == p, inject ? "R8" : "R3", "magnitude",
              80'({s_ac[SM-1:0], s_mq[SM-1:0]}), 80'(p));
        check(s_ac[SW-1] == sg && s_mq[SW-1] == sg, (p == 0) ? "R5" : "R4", "sign",
              80'({s_ac[SW-1], s_mq[SW-1]}), 80'({sg, sg}));
        @(negedge clk);
        check(s_done == 1'b0, "R7", "done one cycle", 80'(s_done), 80'(0));
    endtask

    task automatic run_w(input logic [LW-1:0] a, input logic [LW-1:0] b);
        logic [79:0] p;
        logic        sg;
        int          lat;
        p  = {41'b0, a[LM-1:0]} * {41'b0, b[LM-1:0]};
        sg = (a[LW-1] ^ b[LW-1]) && (p != 0);
        @(negedge clk);
        w_a = a; w_b = b; w_start = 1'b1;
        @(negedge clk);
        w_start = 1'b0;
        lat = 0;
        while (!w_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(lat == LW, "R6", "wide latency", 80'(lat), 80'(LW));
        check(w_ac == {sg, p[2*LM-1:LM]}, "R3", "wide AC", 80'(w_ac), 80'({sg, p[2*LM-1:LM]}));
        check(w_mq == {sg, p[LM-1:0]}, "R4", "wide MQ", 80'(w_mq), 80'({sg, p[LM-1:0]}));
        @(negedge clk);
        check(w_done == 1'b0, "R7", "wide done one cycle", 80'(w_done), 80'(0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [SW-1:0] hold_ac;
        logic [SW-1:0] hold_mq;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!s_busy && !s_done, "R1", "small flags", 80'({s_busy, s_done}), 80'(0));
        check(s_ac == '0 && s_mq == '0, "R1", "small regs", 80'({s_ac, s_mq}), 80'(0));
        check(!w_busy && !w_done && w_ac == '0 && w_mq == '0, "R1", "wide state",
              80'({w_busy, w_done}), 80'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5: exhaustive sweep
        for (int i = 0; i < (1 << SW); i++) begin
            for (int j = 0; j < (1 << SW); j++) begin
                run_s(SW'(i), SW'(j), 1'b0);
            end
        end

        // R8: start pulse during busy is ignored
        run_s(6'b100111, 6'b001011, 1'b1);
        run_s(6'b011111, 6'b111111, 1'b1);

        // R9: results held while idle with changing inputs
        hold_ac = s_ac;
        hold_mq = s_mq;
        for (int k = 0; k < 6; k++) begin
            s_a = SW'(k * 11); s_b = SW'(k * 7 + 3);
            @(negedge clk);
        end
        check(s_ac == hold_ac && s_mq == hold_mq && !s_busy, "R9", "idle hold",
              80'({s_ac, s_mq}), 80'({hold_ac, hold_mq}));

        // Full-width directed cases
        run_w({1'b0, {LM{1'b1}}}, {1'b0, {LM{1'b1}}});
        run_w({1'b1, {LM{1'b1}}}, {1'b0, {LM{1'b1}}});
        run_w({1'b1, 39'd1}, {1'b1, 39'h40_0000_0000});
        run_w({1'b1, 39'd0}, {1'b0, 39'h12_3456_789A});
        run_w({1'b0, 39'h55_5555_5555}, {1'b1, 39'h2A_AAAA_AAAB});
        run_w({1'b0, 39'd3}, {1'b1, 39'd5});

        finish_run();
    end

endmodule